// File: doc/BRIEF.md
# LIN Slave Bus Timeout Supervisor

This block keeps the time-based side of a LIN slave node. It counts milliseconds from an external 1 ms tick strobe. It watches a bus-activity strobe from the frame logic. When the node is awake and the bus stays quiet for a selectable multi-second period, it raises an idle flag and puts the node to sleep. A sleep-mode frame strobe also puts the node to sleep.

While the node sleeps, a wakeup request strobe from the host makes the block emit a one-cycle request for a wakeup pulse on the wire, and the node leaves sleep. The block then waits for a sync field. If none comes, the wakeup is repeated at a selectable interval, up to a fixed number of attempts. If no sync arrives within a fixed window after the last attempt, the block gives a one-cycle timeout strobe and returns the node to sleep. Pulse shaping on the wire and frame decoding live in neighbouring blocks.

All timing is expressed in ticks. With the default parameters, one tick is one millisecond.

Top module: `lin_bus_timer_sup`

## Requirements
- R1: After synchronous reset the node is awake, and `sleep_o`, `idle_to_o`, `wup_pulse_o` and `sync_to_o` are all low.
- R2: The idle period is selected by `idle_sel_i`: 00 gives 4000 ticks, 01 gives 6000, 10 gives 8000 and 11 gives 10000. `idle_to_o` rises in the clock cycle after the tick that completes the period. The period is measured from the last bus activity, or from the sync that ended a wakeup.
- R3: A bus activity strobe while the node is awake restarts the idle count from zero.
- R4: A bus activity strobe clears `idle_to_o` in the next cycle, in any state. It does not change `sleep_o`.
- R5: A sleep-frame strobe while the node is awake raises `sleep_o` in the next cycle and does not raise `idle_to_o`.
- R6: An idle timeout raises `sleep_o` in the same cycle as `idle_to_o`.
- R7: A wakeup request strobe while asleep gives exactly one single-cycle `wup_pulse_o` in the next cycle. `sleep_o` falls in that same cycle.
- R8: A sync strobe while waiting after a wakeup returns the node to awake. No further wakeup pulses follow, and no timeout is raised.
- R9: While waiting for sync, a wakeup pulse is repeated every repeat interval after the previous pulse, for 3 pulses in total. The interval is selected by `rpt_sel_i`: 00 gives 180 ticks, 01 gives 200, 10 gives 220 and 11 gives 240.
- R10: If 150 ticks pass after the last wakeup pulse with no sync, `sync_to_o` pulses for one cycle and `sleep_o` rises in the same cycle.
- R11: A wakeup request strobe while the node is not asleep is ignored: no pulse is produced and the state does not change.
- R12: The timing counters advance only on cycles where `tick_i` is high, and they saturate instead of wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick_i | input | 1 | 1 ms time base strobe |
| bus_act_i | input | 1 | Bus activity seen, one-cycle strobe |
| sync_det_i | input | 1 | Sync field detected, one-cycle strobe |
| wake_req_i | input | 1 | Host wakeup request, one-cycle strobe |
| sleep_frm_i | input | 1 | Sleep-mode frame received, one-cycle strobe |
| idle_sel_i | input | 2 | Idle period select |
| rpt_sel_i | input | 2 | Wakeup repeat interval select |
| wup_pulse_o | output | 1 | Request to drive one wakeup pulse, one cycle |
| idle_to_o | output | 1 | Bus idle timeout flag |
| sync_to_o | output | 1 | No-sync-after-wakeup timeout strobe |
| sleep_o | output | 1 | Node is in sleep state |

## Verification
The assertions assume that every event input is a single-cycle strobe. They also assume that the select fields stay stable while a period they choose is being timed, since the limits are decoded live. The stimulus follows these rules: it drives each strobe for exactly one clock on the falling edge, never puts two strobes in the same cycle, and changes the select fields only before the event that starts the period they govern. Expected event cycles are predicted from the cycle in which each strobe is taken, then compared by a scoreboard that also flags any event it did not expect.

// File: rtl/lbt_pkg.sv
package lbt_pkg;

    typedef enum logic [1:0] {
        NODE_AWAKE  = 2'd0,
        NODE_ASLEEP = 2'd1,
        NODE_WAKING = 2'd2
    } node_state_e;

    typedef struct packed {
        logic clr;
        logic inc;
    } cnt_ctl_s;

    // period = base + step * select
    function automatic int unsigned sel_period(input int unsigned base,
                                               input int unsigned step,
                                               input logic [1:0] sel);
        return base + step * int'(sel);
    endfunction

endpackage

// File: rtl/lbt_tick_cnt.sv
module lbt_tick_cnt
    import lbt_pkg::*;
#(
    parameter int unsigned W = 14
) (
    input  logic           clk,
    input  logic           rst,
    input  cnt_ctl_s       ctl,
    output logic [W-1:0]   cnt
);
    localparam logic [W-1:0] CNT_MAX = {W{1'b1}};

    always_ff @(posedge clk) begin
        if (rst || ctl.clr) begin
            cnt <= '0;
        end else if (ctl.inc && cnt != CNT_MAX) begin
            cnt <= cnt + W'(1);
        end
    end

    assert_no_wrap_R12: assert property (@(posedge clk) disable iff (rst)
        (cnt == CNT_MAX && ctl.inc && !ctl.clr) |=> (cnt == CNT_MAX));

    assert_hold_no_tick_R12: assert property (@(posedge clk) disable iff (rst)
        (!ctl.inc && !ctl.clr) |=> $stable(cnt));

endmodule

// File: rtl/lbt_sup_fsm.sv
module lbt_sup_fsm
    import lbt_pkg::*;
#(
    parameter int unsigned CNT_W     = 14,
    parameter int unsigned IDLE_BASE = 4000,
    parameter int unsigned IDLE_STEP = 2000,
    parameter int unsigned RPT_BASE  = 180,
    parameter int unsigned RPT_STEP  = 20,
    parameter int unsigned SYNC_WIN  = 150,
    parameter int unsigned TRIES     = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_i,
    input  logic             bus_act_i,
    input  logic             sync_det_i,
    input  logic             wake_req_i,
    input  logic             sleep_frm_i,
    input  logic [1:0]       idle_sel_i,
    input  logic [1:0]       rpt_sel_i,
    input  logic [CNT_W-1:0] idle_cnt,
    input  logic [CNT_W-1:0] win_cnt,
    output cnt_ctl_s         idle_ctl,
    output cnt_ctl_s         win_ctl,
    output logic             wup_pulse_o,
    output logic             idle_to_o,
    output logic             sync_to_o,
    output logic             sleep_o
);
    localparam int unsigned   TRY_W     = $clog2(TRIES + 1);
    localparam logic [TRY_W-1:0] TRY_LAST = TRY_W'(TRIES);
    localparam logic [CNT_W-1:0] SYNC_LAST = CNT_W'(SYNC_WIN - 1);

    node_state_e      st, st_n;
    logic [TRY_W-1:0] tries, tries_n;
    logic             pulse_n, flag_n, sto_n;
    logic [CNT_W-1:0] idle_lim, rpt_lim;

    always_comb begin
        idle_lim = CNT_W'(sel_period(IDLE_BASE, IDLE_STEP, idle_sel_i));
        rpt_lim  = CNT_W'(sel_period(RPT_BASE, RPT_STEP, rpt_sel_i));
    end

    always_comb begin
        st_n     = st;
        tries_n  = tries;
        pulse_n  = 1'b0;
        sto_n    = 1'b0;
        flag_n   = idle_to_o & ~bus_act_i;
        idle_ctl = '{clr: 1'b1, inc: 1'b0};
        win_ctl  = '{clr: 1'b1, inc: 1'b0};
        case (st)
            NODE_AWAKE: begin
                if (sleep_frm_i) begin
                    st_n = NODE_ASLEEP;
                end else if (!bus_act_i) begin
                    idle_ctl = '{clr: 1'b0, inc: tick_i};
                    if (tick_i && idle_cnt >= idle_lim - CNT_W'(1)) begin
                        flag_n = 1'b1;
                        st_n   = NODE_ASLEEP;
                    end
                end
            end
            NODE_ASLEEP: begin
                if (wake_req_i) begin
                    st_n    = NODE_WAKING;
                    pulse_n = 1'b1;
                    tries_n = TRY_W'(1);
                end
            end
            NODE_WAKING: begin
                if (sync_det_i) begin
                    st_n = NODE_AWAKE;
                end else begin
                    win_ctl = '{clr: 1'b0, inc: tick_i};
                    if (tick_i) begin
                        if (tries < TRY_LAST && win_cnt >= rpt_lim - CNT_W'(1)) begin
                            pulse_n     = 1'b1;
                            tries_n     = tries + TRY_W'(1);
                            win_ctl.clr = 1'b1;
                        end else if (tries >= TRY_LAST && win_cnt >= SYNC_LAST) begin
                            sto_n = 1'b1;
                            st_n  = NODE_ASLEEP;
                        end
                    end
                end
            end
            default: st_n = NODE_AWAKE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st          <= NODE_AWAKE;
            tries       <= '0;
            wup_pulse_o <= 1'b0;
            idle_to_o   <= 1'b0;
            sync_to_o   <= 1'b0;
        end else begin
            st          <= st_n;
            tries       <= tries_n;
            wup_pulse_o <= pulse_n;
            idle_to_o   <= flag_n;
            sync_to_o   <= sto_n;
        end
    end

    assign sleep_o = (st == NODE_ASLEEP);

    assert_idle_sleeps_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(idle_to_o) |-> sleep_o);

    assert_sleep_frame_R5: assert property (@(posedge clk) disable iff (rst)
        (st == NODE_AWAKE && sleep_frm_i) |=> (sleep_o && !$rose(idle_to_o)));

    assert_single_pulse_R7: assert property (@(posedge clk) disable iff (rst)
        wup_pulse_o |=> !wup_pulse_o);

    assert_sync_wakes_R8: assert property (@(posedge clk) disable iff (rst)
        (st == NODE_WAKING && sync_det_i) |=> (!sleep_o && !sync_to_o && !wup_pulse_o));

    assert_timeout_sleeps_R10: assert property (@(posedge clk) disable iff (rst)
        sync_to_o |-> sleep_o);

    assert_wake_ignored_R11: assert property (@(posedge clk) disable iff (rst)
        (st == NODE_AWAKE && wake_req_i) |=> !wup_pulse_o);

endmodule

// File: rtl/lin_bus_timer_sup.sv
module lin_bus_timer_sup
    import lbt_pkg::*;
#(
    parameter int unsigned IDLE_BASE = 4000,
    parameter int unsigned IDLE_STEP = 2000,
    parameter int unsigned RPT_BASE  = 180,
    parameter int unsigned RPT_STEP  = 20,
    parameter int unsigned SYNC_WIN  = 150,
    parameter int unsigned TRIES     = 3
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick_i,
    input  logic       bus_act_i,
    input  logic       sync_det_i,
    input  logic       wake_req_i,
    input  logic       sleep_frm_i,
    input  logic [1:0] idle_sel_i,
    input  logic [1:0] rpt_sel_i,
    output logic       wup_pulse_o,
    output logic       idle_to_o,
    output logic       sync_to_o,
    output logic       sleep_o
);
    localparam int unsigned IDLE_MAX = IDLE_BASE + 3 * IDLE_STEP;
    localparam int unsigned CNT_W    = $clog2(IDLE_MAX + 1);

    cnt_ctl_s         idle_ctl, win_ctl;
    logic [CNT_W-1:0] idle_cnt, win_cnt;

    lbt_tick_cnt #(.W(CNT_W)) u_idle_cnt (
        .clk (clk),
        .rst (rst),
        .ctl (idle_ctl),
        .cnt (idle_cnt)
    );

    lbt_tick_cnt #(.W(CNT_W)) u_win_cnt (
        .clk (clk),
        .rst (rst),
        .ctl (win_ctl),
        .cnt (win_cnt)
    );

    lbt_sup_fsm #(
        .CNT_W     (CNT_W),
        .IDLE_BASE (IDLE_BASE),
        .IDLE_STEP (IDLE_STEP),
        .RPT_BASE  (RPT_BASE),
        .RPT_STEP  (RPT_STEP),
        .SYNC_WIN  (SYNC_WIN),
        .TRIES     (TRIES)
    ) u_fsm (
        .clk         (clk),
        .rst         (rst),
        .tick_i      (tick_i),
        .bus_act_i   (bus_act_i),
        .sync_det_i  (sync_det_i),
        .wake_req_i  (wake_req_i),
        .sleep_frm_i (sleep_frm_i),
        .idle_sel_i  (idle_sel_i),
        .rpt_sel_i   (rpt_sel_i),
        .idle_cnt    (idle_cnt),
        .win_cnt     (win_cnt),
        .idle_ctl    (idle_ctl),
        .win_ctl     (win_ctl),
        .wup_pulse_o (wup_pulse_o),
        .idle_to_o   (idle_to_o),
        .sync_to_o   (sync_to_o),
        .sleep_o     (sleep_o)
    );

endmodule

// File: tb/lin_bus_timer_sup_test.sv
module lin_bus_timer_sup_test;

    typedef enum int {EV_WUP, EV_IDLE, EV_STO} ev_e;
    typedef struct {
        ev_e         kind;
        int unsigned at;
        string       req;
    } exp_item_t;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic       rst = 1'b1;
    logic       tick_i = 1'b1;
    logic       bus_act_i = 1'b0, sync_det_i = 1'b0, wake_req_i = 1'b0, sleep_frm_i = 1'b0;
    logic [1:0] idle_sel_i = 2'd0, rpt_sel_i = 2'd0;
    logic       wup_pulse_o, idle_to_o, sync_to_o, sleep_o;

    lin_bus_timer_sup uut (
        .clk(clk), .rst(rst), .tick_i(tick_i), .bus_act_i(bus_act_i),
        .sync_det_i(sync_det_i), .wake_req_i(wake_req_i), .sleep_frm_i(sleep_frm_i),
        .idle_sel_i(idle_sel_i), .rpt_sel_i(rpt_sel_i),
        .wup_pulse_o(wup_pulse_o), .idle_to_o(idle_to_o),
        .sync_to_o(sync_to_o), .sleep_o(sleep_o)
    );

    int unsigned cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    exp_item_t   expq[$];
    int          n_chk = 0;
    int          n_bad = 0;
    int          wup_seen = 0;
    logic        idle_prev = 1'b0;

    task automatic chk(input logic ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic expect_ev(input ev_e k, input int unsigned at, input string req);
        exp_item_t it;
        it.kind = k; it.at = at; it.req = req;
        expq.push_back(it);
    endtask

    task automatic seen_ev(input ev_e k);
        exp_item_t it;
        if (expq.size() == 0) begin
            n_chk++; n_bad++;
            $display("FAIL %s unexpected event kind=%0d actual_cycle=%0d expected=none",
                     (k == EV_WUP) ? "R9" : (k == EV_STO) ? "R8" : "R3", int'(k), cyc);
        end else begin
            it = expq.pop_front();
            chk(it.kind == k, it.req, "event kind", int'(k), int'(it.kind));
            chk(it.at == cyc, it.req, "event cycle", int'(cyc), int'(it.at));
        end
    endtask

    // monitor: samples 2 ns after the rising edge
    always begin
        @(posedge clk);
        #2;
        if (!rst) begin
            if (wup_pulse_o) begin
                wup_seen++;
                seen_ev(EV_WUP);
            end
            if (sync_to_o) seen_ev(EV_STO);
            if (idle_to_o && !idle_prev) seen_ev(EV_IDLE);
        end
        idle_prev = idle_to_o;
    end

    // 0 activity, 1 sync, 2 wake, 3 sleep frame; returns the cycle that takes it
    task automatic strobe(input int which, output int unsigned at);
        at = cyc + 1;
        case (which)
            0: bus_act_i = 1'b1;
            1: sync_det_i = 1'b1;
            2: wake_req_i = 1'b1;
            default: sleep_frm_i = 1'b1;
        endcase
        @(negedge clk);
        bus_act_i = 1'b0; sync_det_i = 1'b0; wake_req_i = 1'b0; sleep_frm_i = 1'b0;
    endtask

    task automatic wait_past(input int unsigned c);
        while (cyc < c + 1) @(negedge clk);
    endtask

    task automatic wake_then_sync();
        int unsigned w, s;
        expect_ev(EV_WUP, cyc + 1, "R7");
        strobe(2, w);
        repeat (10) @(negedge clk);
        strobe(1, s);
    endtask

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL R1 watchdog actual=running expected=finished");
        summary();
        $finish;
    end

    initial begin
        int unsigned a, a2, w, s, t;
        int n;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(!sleep_o, "R1", "sleep_o", int'(sleep_o), 0);
        chk(!idle_to_o, "R1", "idle_to_o", int'(idle_to_o), 0);
        chk(!wup_pulse_o, "R1", "wup_pulse_o", int'(wup_pulse_o), 0);
        chk(!sync_to_o, "R1", "sync_to_o", int'(sync_to_o), 0);

        // R2 / R6: 4000-tick idle period
        idle_sel_i = 2'd0;
        expect_ev(EV_IDLE, cyc + 1 + 4000, "R2");
        strobe(0, a);
        wait_past(a + 4000);
        chk(sleep_o, "R6", "sleep after idle", int'(sleep_o), 1);

        // R4: activity while asleep clears flag, keeps sleep
        strobe(0, a);
        chk(!idle_to_o, "R4", "idle flag cleared", int'(idle_to_o), 0);
        chk(sleep_o, "R4", "sleep kept", int'(sleep_o), 1);

        // R7 / R8 / R11 / R2 (10000 ticks)
        idle_sel_i = 2'd3;
        rpt_sel_i  = 2'd0;
        expect_ev(EV_WUP, cyc + 1, "R7");
        strobe(2, w);
        chk(!sleep_o, "R7", "sleep left on wake", int'(sleep_o), 0);
        repeat (50) @(negedge clk);
        expect_ev(EV_IDLE, cyc + 1 + 10000, "R2");
        strobe(1, s);
        chk(!sleep_o, "R8", "awake after sync", int'(sleep_o), 0);
        n = wup_seen;
        repeat (5) @(negedge clk);
        strobe(2, a);
        repeat (300) @(negedge clk);
        chk(wup_seen == n, "R11", "pulses after ignored wake", wup_seen, n);
        chk(!sleep_o, "R11", "state after ignored wake", int'(sleep_o), 0);
        wait_past(s + 10000);
        chk(sleep_o, "R6", "sleep after 10000 idle", int'(sleep_o), 1);

        // R3: activity restarts the 6000-tick count
        idle_sel_i = 2'd1;
        wake_then_sync();
        repeat (20) @(negedge clk);
        strobe(0, a);
        repeat (5000) @(negedge clk);
        expect_ev(EV_IDLE, cyc + 1 + 6000, "R3");
        strobe(0, a2);
        wait_past(a2 + 6000);
        chk(sleep_o, "R3", "sleep after restarted idle", int'(sleep_o), 1);

        // R9 / R10: three pulses 220 apart, then 150-tick timeout
        rpt_sel_i = 2'd2;
        w = cyc + 1;
        expect_ev(EV_WUP, w, "R7");
        expect_ev(EV_WUP, w + 220, "R9");
        expect_ev(EV_WUP, w + 440, "R9");
        expect_ev(EV_STO, w + 590, "R10");
        strobe(2, w);
        wait_past(w + 590);
        chk(sleep_o, "R10", "sleep after sync timeout", int'(sleep_o), 1);

        // R9 / R8: 180 interval, sync after the second pulse
        rpt_sel_i = 2'd0;
        w = cyc + 1;
        expect_ev(EV_WUP, w, "R7");
        expect_ev(EV_WUP, w + 180, "R9");
        strobe(2, w);
        wait_past(w + 198);
        strobe(1, s);
        chk(s == w + 200, "R8", "sync cycle", int'(s), int'(w + 200));
        repeat (400) @(negedge clk);
        chk(!sleep_o, "R8", "no timeout after sync", int'(sleep_o), 0);

        // R5: sleep frame
        strobe(0, a);
        strobe(3, a);
        chk(sleep_o, "R5", "sleep after frame", int'(sleep_o), 1);
        chk(!idle_to_o, "R5", "no idle flag on frame", int'(idle_to_o), 0);

        // R12: no tick, no progress
        idle_sel_i = 2'd0;
        wake_then_sync();
        tick_i = 1'b0;
        strobe(0, a);
        repeat (5000) @(negedge clk);
        chk(!idle_to_o, "R12", "idle without ticks", int'(idle_to_o), 0);
        t = cyc;
        expect_ev(EV_IDLE, t + 4000, "R12");
        tick_i = 1'b1;
        wait_past(t + 4000);

        repeat (10) @(negedge clk);
        chk(expq.size() == 0, "R2", "pending expected events", expq.size(), 0);
        summary();
        $finish;
    end

endmodule